// File: doc/BRIEF.md
# Serial Memory Status Register Engine

This block is the slave-side status logic of a single-wire serial memory. It receives bytes that a line decoder has already recovered, each one tagged with whether the master acknowledged it. It walks the frame opening, decodes the command, and keeps a small status register. That register holds a write-enable latch, a busy flag for the internal write cycle, and two nonvolatile block-protect bits. It answers status reads by offering bytes on a valid/ready handshake. After each byte it waits for the master's acknowledge outcome.

For a status read, a master acknowledge makes the block capture the status again and offer it once more. The busy and latch bits are sampled at that moment. This lets the master poll the end of a write without sending a new command. A no-acknowledge closes the read. The internal write cycle is modelled by a counter, `WRITE_CYCLES` clocks long. At the end of the cycle the write-enable latch drops by itself.

Top module: `ee_status_engine`

## Requirements
- R1: The status byte carries the busy flag in bit 0, the write-enable latch in bit 1, block-protect 0 in bit 2 and block-protect 1 in bit 3. Bits 7 to 4 are always zero.
- R2: A frame opens with byte 0x55 carrying a master acknowledge. Next comes 0xA0 with an acknowledge, then a command byte. Command 0x05 with an acknowledge raises `txValid` in the cycle after that byte, holding the status.
- R3: While `txValid` is high and `txReady` is low, `txValid` stays high and `txData` does not change.
- R4: After the byte has been taken, `ackValid` with `ackMak`=1 recaptures the status with its current bit values and raises `txValid` in the next cycle. With `ackMak`=0, the read ends and `txValid` stays low.
- R5: Command 0x06 sets the write-enable latch and command 0x04 clears it. Both are ignored while the busy flag is set.
- R6: Command 0x01 with an acknowledge, followed by a data byte, writes data bits 3:2 into block-protect 1:0. This happens only when the latch is 1 and the busy flag is 0. The latch and busy bits cannot be written this way.
- R7: An accepted status write holds the busy flag high for exactly `WRITE_CYCLES` cycles, starting the cycle after the data byte. The latch is cleared in the same cycle that the busy flag falls.
- R8: A status read during a write cycle returns the newly written block-protect bits with the busy flag set.
- R9: Reset clears the latch and the busy flag and leaves `txValid` low. The block-protect bits keep their values across reset and start at `BP_INIT`.
- R10: A wrong header or device address, a missing acknowledge, or an unknown command returns the block to idle without transmitting. A new 0x55 header is then needed.
- R11: A rejected status write leaves the block-protect bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | A received byte is present this cycle |
| rxData | input | 8 | Received byte |
| rxMak | input | 1 | Master acknowledged the received byte |
| txValid | output | 1 | Status byte offered for transmission |
| txData | output | 8 | Status byte to transmit |
| txReady | input | 1 | Line side takes the offered byte |
| ackValid | input | 1 | Master acknowledge outcome after a transmitted byte |
| ackMak | input | 1 | 1 = acknowledge (repeat), 0 = no acknowledge (stop) |

## Verification
A command byte sampled at one rising edge shows its effect after that edge. `txValid` and the captured status appear one cycle after the read command or the repeating acknowledge. The busy flag spans `WRITE_CYCLES` edges after the data byte. The bench drives every input and samples every output at falling edges. It places a status read so that its capture edge falls on the last busy cycle, and another on the first idle cycle, to pin the write-cycle length exactly. Repeated reads are captured after a long wait, so the busy and latch bits they return must be the current ones.

// File: rtl/ee_status_pkg.sv
package ee_status_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] HDR_BYTE = 8'h55;
  localparam logic [BYTE_W-1:0] DEV_ADDR = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] CMD_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] CMD_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_WRSR = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DATA, ST_SEND, ST_WAIT
  } ctrlState_t;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startWrite;
    logic loadTx;
  } strobes_t;
endpackage

// File: rtl/ee_status_ctrl.sv
module ee_status_ctrl
  import ee_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxMak,
  input  logic              txReady,
  input  logic              ackValid,
  input  logic              ackMak,
  input  logic              wel,
  input  logic              wip,
  output logic              txValid,
  output strobes_t          strb
);
  ctrlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    txValid   = (state == ST_SEND);
    case (state)
      ST_IDLE: if (rxValid && rxMak && rxData == HDR_BYTE) nextState = ST_ADDR;
      ST_ADDR: if (rxValid) nextState = (rxMak && rxData == DEV_ADDR) ? ST_CMD : ST_IDLE;
      ST_CMD: if (rxValid) begin
        nextState = ST_IDLE;
        case (rxData)
          CMD_RDSR: if (rxMak) begin
            nextState   = ST_SEND;
            strb.loadTx = 1'b1;
          end
          CMD_WREN: strb.setWel = !wip;
          CMD_WRDI: strb.clrWel = !wip;
          CMD_WRSR: if (rxMak) nextState = ST_DATA;
          default: ;
        endcase
      end
      ST_DATA: if (rxValid) begin
        nextState       = ST_IDLE;
        strb.startWrite = wel && !wip;
      end
      ST_SEND: if (txReady) nextState = ST_WAIT;
      ST_WAIT: if (ackValid) begin
        if (ackMak) begin
          nextState   = ST_SEND;
          strb.loadTx = 1'b1;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_BAD_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && rxValid && rxData != DEV_ADDR) |=> state == ST_IDLE); // R10
  AST_NOMAK_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && ackValid && !ackMak) |=> !txValid); // R4
  AST_MAK_REPEATS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && ackValid && ackMak) |=> txValid); // R4
endmodule

// File: rtl/ee_status_dp.sv
module ee_status_dp
  import ee_status_pkg::*;
#(
  parameter int         WRITE_CYCLES = 1000,
  parameter logic [1:0] BP_INIT      = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [1:0]        bpIn,
  output logic              wel,
  output logic              wip,
  output logic [BYTE_W-1:0] txData
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  // Nonvolatile block-protect bits: no reset, erased value at power-up.
  logic [1:0] bpReg = BP_INIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
      wip <= 1'b0;
      cnt <= '0;
    end else begin
      if (strb.startWrite) begin
        wip <= 1'b1;
        cnt <= CNT_W'(WRITE_CYCLES);
      end else if (wip) begin
        if (cnt == CNT_W'(1)) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (strb.setWel)      wel <= 1'b1;
      else if (strb.clrWel) wel <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.startWrite) bpReg <= bpIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txData <= '0;
    else if (strb.loadTx) txData <= {{(BYTE_W-4){1'b0}}, bpReg, wel, wip};
  end

  AST_WEL_SET_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(strb.setWel)); // R5
  AST_WEL_CLR_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wel) |-> ($past(strb.clrWel) || $fell(wip))); // R7
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWrite |-> (wel && !wip)); // R6
  AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.startWrite |=> $stable(bpReg)); // R11
  AST_WIP_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel); // R7
endmodule

// File: rtl/ee_status_engine.sv
module ee_status_engine
  import ee_status_pkg::*;
#(
  parameter int         WRITE_CYCLES = 1000,
  parameter logic [1:0] BP_INIT      = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxMak,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  input  logic              ackValid,
  input  logic              ackMak
);
  strobes_t strb;
  logic     wel, wip;

  ee_status_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxMak(rxMak),
    .txReady(txReady), .ackValid(ackValid), .ackMak(ackMak),
    .wel(wel), .wip(wip), .txValid(txValid), .strb(strb)
  );

  ee_status_dp #(.WRITE_CYCLES(WRITE_CYCLES), .BP_INIT(BP_INIT)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bpIn(rxData[3:2]),
    .wel(wel), .wip(wip), .txData(txData)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData))); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> txData[BYTE_W-1:4] == '0); // R1
endmodule

// File: tb/test_ee_status_engine.sv
module test_ee_status_engine;
  localparam int WC = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0, rxMak = 1'b0, txReady = 1'b0, ackValid = 1'b0, ackMak = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       txValid;
  logic [7:0] txData;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ee_status_engine #(.WRITE_CYCLES(WC), .BP_INIT(2'b00)) i_ee_status_engine (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxMak(rxMak),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .ackValid(ackValid), .ackMak(ackMak)
  );

  // {opcode, data byte, expected status after the write cycle has ended}
  localparam logic [23:0] VEC [9] = '{
    {8'h06, 8'h00, 8'h02},  // R5 set latch
    {8'h04, 8'h00, 8'h00},  // R5 clear latch
    {8'h01, 8'h0C, 8'h00},  // R11 rejected, latch low
    {8'h06, 8'h00, 8'h02},
    {8'h01, 8'hFF, 8'h0C},  // R6 only bits 3:2 stored, R7 latch auto-cleared
    {8'h06, 8'h00, 8'h0E},  // R1 layout
    {8'h01, 8'h04, 8'h04},
    {8'h04, 8'h00, 8'h04},
    {8'h07, 8'h00, 8'h04}   // R10 unknown command
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic m);
    rxData = b; rxMak = m; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic accept();
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic ack(input logic m);
    ackValid = 1'b1; ackMak = m;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic openRead();
    sendByte(8'h55, 1'b1);
    sendByte(8'hA0, 1'b1);
    sendByte(8'h05, 1'b1);
  endtask

  task automatic readStatus(input string req, input logic [7:0] exp);
    openRead();
    check(req, {7'b0, txValid}, 8'h01);
    check(req, txData, exp);
    accept();
    ack(1'b0);
    check("R4", {7'b0, txValid}, 8'h00);
  endtask

  task automatic command(input logic [7:0] op, input logic [7:0] d);
    sendByte(8'h55, 1'b1);
    sendByte(8'hA0, 1'b1);
    if (op == 8'h01) begin
      sendByte(op, 1'b1);
      sendByte(d, 1'b0);
    end else begin
      sendByte(op, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", {7'b0, txValid}, 8'h00);
    readStatus("R9", 8'h00);

    for (int i = 0; i < 9; i++) begin
      command(VEC[i][23:16], VEC[i][15:8]);
      repeat (WC + 2) @(negedge clk);
      readStatus("R1", VEC[i][7:0]);
    end

    // R3: byte held while the line side is not ready
    openRead();
    check("R3", txData, 8'h04);
    repeat (3) @(negedge clk);
    check("R3", {7'b0, txValid}, 8'h01);
    check("R3", txData, 8'h04);
    accept();
    ack(1'b0);
    repeat (2) @(negedge clk);
    check("R4", {7'b0, txValid}, 8'h00);

    // R8/R5: write-disable ignored and new protect bits visible mid-cycle
    command(8'h06, 8'h00);
    command(8'h01, 8'h08);
    command(8'h04, 8'h00);
    openRead();
    check("R8", txData, 8'h0B);
    accept();
    repeat (WC + 2) @(negedge clk);
    ack(1'b1);
    check("R4", {7'b0, txValid}, 8'h01);
    check("R4", txData, 8'h08);  // live resample: busy and latch now low
    accept();
    ack(1'b0);

    // R7: exact busy length, capture on last busy cycle then first idle cycle
    command(8'h06, 8'h00);
    command(8'h01, 8'h00);
    repeat (WC - 3) @(negedge clk);
    readStatus("R7", 8'h03);
    repeat (WC + 2) @(negedge clk);
    command(8'h06, 8'h00);
    command(8'h01, 8'h0C);
    repeat (WC - 2) @(negedge clk);
    readStatus("R7", 8'h0C);

    // R10/R2: malformed frames never transmit
    sendByte(8'h55, 1'b1); sendByte(8'hA1, 1'b1); sendByte(8'h05, 1'b1);
    check("R10", {7'b0, txValid}, 8'h00);
    sendByte(8'h55, 1'b0); sendByte(8'hA0, 1'b1); sendByte(8'h05, 1'b1);
    check("R2", {7'b0, txValid}, 8'h00);
    sendByte(8'h55, 1'b1); sendByte(8'hA0, 1'b1); sendByte(8'h07, 1'b1);
    sendByte(8'h05, 1'b1);
    check("R10", {7'b0, txValid}, 8'h00);
    readStatus("R2", 8'h0C);

    // R9: protect bits survive reset, latch does not
    command(8'h06, 8'h00);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", {7'b0, txValid}, 8'h00);
    readStatus("R9", 8'h0C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule